// File: doc/BRIEF.md
# Carry-Lookahead Adder

This block adds two unsigned or two's-complement operands with a carry-in and produces the sum and the carry-out. The operands are split into slices of `BLK_W` bits. Each slice forms a generate term (both bits set) and a propagate term (bits differ) for every bit position. Every carry inside a slice is then computed directly as a flat sum of products of those terms and the slice carry-in, so no carry waits on the carry of the bit below it.

Each slice also reports a group generate flag and a group propagate flag, so a higher-level lookahead stage could use them. Inside this block the slices are chained: the carry-out of one slice is the carry-in of the next. The block is purely combinational. With `NUM_BLOCKS = 1` it is a single lookahead slice. With the default of four 4-bit slices it is a 16-bit adder.

Top module: `cla_adder`

## Requirements
- R1: `sum_o` equals the low `BLK_W*NUM_BLOCKS` bits of `a_i + b_i + carry_i`, for every operand value.
- R2: `carry_o` equals bit `BLK_W*NUM_BLOCKS` of `a_i + b_i + carry_i`.
- R3: Bit k of `blk_prop_o` is 1 exactly when every bit of slice k of `a_i` differs from the same bit of `b_i`. Slice k covers bits `k*BLK_W` to `k*BLK_W+BLK_W-1`.
- R4: Bit k of `blk_gen_o` is 1 exactly when slice k of `a_i` plus slice k of `b_i`, with no carry-in, overflows `BLK_W` bits. It does not depend on `carry_i` or on other slices.
- R5: For a single slice (`NUM_BLOCKS = 1`), `carry_o` equals `blk_gen_o | (blk_prop_o & carry_i)`.
- R6: When a slice's group propagate flag is 1, its carry-out equals its carry-in. With a single slice and `a_i ^ b_i` all ones, `carry_o` equals `carry_i` and `sum_o` equals the inverse of `carry_i` replicated.
- R7: A carry entering slice 0 reaches the top slice across all slice boundaries. For all-ones plus zero with `carry_i = 1`, `sum_o` is 0 and `carry_o` is 1.
- R8: All outputs are combinational functions of the current inputs and hold no state. Results are valid in the same clock period in which the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | BLK_W*NUM_BLOCKS | First operand |
| b_i | input | BLK_W*NUM_BLOCKS | Second operand |
| carry_i | input | 1 | Carry into the least significant bit |
| sum_o | output | BLK_W*NUM_BLOCKS | Sum |
| carry_o | output | 1 | Carry out of the most significant bit |
| blk_gen_o | output | NUM_BLOCKS | Group generate flag of each slice |
| blk_prop_o | output | NUM_BLOCKS | Group propagate flag of each slice |

## Verification
Every result is due zero cycles after its stimulus, because no register lies between any input and any output. The bench changes the inputs just after a rising clock edge and samples all outputs at the following falling edge, half a period later, so each check sees settled values for the current vector only. The checks cover an exhaustive sweep of a one-slice instance, a table of directed 16-bit vectors, and random 16-bit vectors.

// File: rtl/cla_pkg.sv
package cla_pkg;

   localparam int MAX_SLICE_W = 8;

   typedef logic [MAX_SLICE_W-1:0] slice_vec_t;

   // Carry into bit position idx, written as an OR of product terms.
   // Each product term is built on its own: there is no reuse of a lower carry.
   function automatic logic flat_carry(input slice_vec_t g,
                                       input slice_vec_t p,
                                       input logic       cin,
                                       input int         idx,
                                       input logic       with_cin);
      logic acc;
      logic term;
      acc = 1'b0;
      for (int j = 0; j < idx; j++) begin
         term = g[j];
         for (int k = j + 1; k < idx; k++) begin
            term = term & p[k];
         end
         acc = acc | term;
      end
      if (with_cin) begin
         term = cin;
         for (int k = 0; k < idx; k++) begin
            term = term & p[k];
         end
         acc = acc | term;
      end
      return acc;
   endfunction

endpackage

// File: rtl/cla_gp_unit.sv
module cla_gp_unit #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   output logic [WIDTH-1:0] gen_o,
   output logic [WIDTH-1:0] prop_o
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign gen_o[i]  = x_i[i] & y_i[i];
      assign prop_o[i] = x_i[i] ^ y_i[i];
   end
endmodule

// File: rtl/cla_carry_net.sv
module cla_carry_net
   import cla_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] gen_i,
   input  logic [WIDTH-1:0] prop_i,
   input  logic             cin_i,
   output logic [WIDTH:0]   carry_o,
   output logic             grp_gen_o,
   output logic             grp_prop_o
);
   slice_vec_t g_pad;
   slice_vec_t p_pad;

   always_comb begin
      g_pad = '0;
      p_pad = '0;
      g_pad[WIDTH-1:0] = gen_i;
      p_pad[WIDTH-1:0] = prop_i;
   end

   assign carry_o[0] = cin_i;

   for (genvar i = 1; i <= WIDTH; i++) begin : g_carry
      assign carry_o[i] = flat_carry(g_pad, p_pad, cin_i, i, 1'b1);
   end

   assign grp_gen_o  = flat_carry(g_pad, p_pad, 1'b0, WIDTH, 1'b0);
   assign grp_prop_o = &prop_i;
endmodule

// File: rtl/cla_block.sv
module cla_block
   import cla_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             grp_gen_o,
   output logic             grp_prop_o
);
   if (WIDTH < 1 || WIDTH > MAX_SLICE_W) begin : g_bad_width
      $error("cla_block: WIDTH must lie in 1..MAX_SLICE_W");
   end

   logic [WIDTH-1:0] gen;
   logic [WIDTH-1:0] prop;
   logic [WIDTH:0]   carry;

   cla_gp_unit #(.WIDTH(WIDTH)) u_gp (
      .x_i    (x_i),
      .y_i    (y_i),
      .gen_o  (gen),
      .prop_o (prop)
   );

   cla_carry_net #(.WIDTH(WIDTH)) u_carry (
      .gen_i      (gen),
      .prop_i     (prop),
      .cin_i      (cin_i),
      .carry_o    (carry),
      .grp_gen_o  (grp_gen_o),
      .grp_prop_o (grp_prop_o)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_sum
      assign sum_o[i] = prop[i] ^ carry[i];
   end

   assign cout_o = carry[WIDTH];
endmodule

// File: rtl/cla_adder.sv
module cla_adder
   import cla_pkg::*;
#(
   parameter int BLK_W      = 4,
   parameter int NUM_BLOCKS = 4
) (
   input  logic [BLK_W*NUM_BLOCKS-1:0] a_i,
   input  logic [BLK_W*NUM_BLOCKS-1:0] b_i,
   input  logic                        carry_i,
   output logic [BLK_W*NUM_BLOCKS-1:0] sum_o,
   output logic                        carry_o,
   output logic [NUM_BLOCKS-1:0]       blk_gen_o,
   output logic [NUM_BLOCKS-1:0]       blk_prop_o
);
   localparam int TOTAL_W = BLK_W * NUM_BLOCKS;

   if (NUM_BLOCKS < 1) begin : g_bad_count
      $error("cla_adder: NUM_BLOCKS must be at least 1");
   end
   if (BLK_W < 1 || BLK_W > MAX_SLICE_W) begin : g_bad_blk
      $error("cla_adder: BLK_W out of supported range");
   end

   logic [NUM_BLOCKS:0] link;
   assign link[0] = carry_i;

   for (genvar k = 0; k < NUM_BLOCKS; k++) begin : g_slice
      cla_block #(.WIDTH(BLK_W)) u_blk (
         .x_i        (a_i[k*BLK_W +: BLK_W]),
         .y_i        (b_i[k*BLK_W +: BLK_W]),
         .cin_i      (link[k]),
         .sum_o      (sum_o[k*BLK_W +: BLK_W]),
         .cout_o     (link[k+1]),
         .grp_gen_o  (blk_gen_o[k]),
         .grp_prop_o (blk_prop_o[k])
      );
   end

   assign carry_o = link[NUM_BLOCKS];

   logic [TOTAL_W-1:0] unused_w;
   assign unused_w = '0;
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
   parameter int BLK_W      = 4,
   parameter int NUM_BLOCKS = 4
) (
   input logic [BLK_W*NUM_BLOCKS-1:0] a_i,
   input logic [BLK_W*NUM_BLOCKS-1:0] b_i,
   input logic                        carry_i,
   input logic [BLK_W*NUM_BLOCKS-1:0] sum_o,
   input logic                        carry_o,
   input logic [NUM_BLOCKS-1:0]       blk_gen_o,
   input logic [NUM_BLOCKS-1:0]       blk_prop_o
);
   localparam int TOTAL_W = BLK_W * NUM_BLOCKS;

   logic [TOTAL_W:0] ref_total;
   assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{TOTAL_W{1'b0}}, carry_i};

   always_comb begin
      p_sum_r1: assert (sum_o == ref_total[TOTAL_W-1:0])
         else $error("R1 sum mismatch");
      p_cout_r2: assert (carry_o == ref_total[TOTAL_W])
         else $error("R2 carry-out mismatch");
   end

   for (genvar k = 0; k < NUM_BLOCKS; k++) begin : g_grp
      logic [BLK_W:0] slice_add;
      assign slice_add = {1'b0, a_i[k*BLK_W +: BLK_W]} + {1'b0, b_i[k*BLK_W +: BLK_W]};
      always_comb begin
         p_prop_r3: assert (blk_prop_o[k] == ((a_i[k*BLK_W +: BLK_W] ^ b_i[k*BLK_W +: BLK_W]) == {BLK_W{1'b1}}))
            else $error("R3 group propagate mismatch");
         p_gen_r4: assert (blk_gen_o[k] == slice_add[BLK_W])
            else $error("R4 group generate mismatch");
      end
   end

   if (NUM_BLOCKS == 1) begin : g_single
      always_comb begin
         p_grp_cout_r5: assert (carry_o == (blk_gen_o[0] | (blk_prop_o[0] & carry_i)))
            else $error("R5 group relation mismatch");
         p_bypass_r6: assert (!blk_prop_o[0] || (carry_o == carry_i))
            else $error("R6 bypass mismatch");
      end
   end
endmodule

bind cla_adder cla_adder_chk #(.BLK_W(BLK_W), .NUM_BLOCKS(NUM_BLOCKS)) u_chk (.*);

// File: tb/cla_adder_tb_top.sv
`timescale 1ns/1ps
module cla_adder_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;

   // wide instance: 4 x 4-bit
   logic [15:0] a, b, s;
   logic        ci, co;
   logic [3:0]  bg, bp;

   cla_adder #(.BLK_W(4), .NUM_BLOCKS(4)) dut_i (
      .a_i(a), .b_i(b), .carry_i(ci), .sum_o(s), .carry_o(co),
      .blk_gen_o(bg), .blk_prop_o(bp)
   );

   // single-slice instance
   logic [3:0] sa, sb, ss;
   logic       sci, sco;
   logic [0:0] sg, sp;

   cla_adder #(.BLK_W(4), .NUM_BLOCKS(1)) dut_one (
      .a_i(sa), .b_i(sb), .carry_i(sci), .sum_o(ss), .carry_o(sco),
      .blk_gen_o(sg), .blk_prop_o(sp)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // wide vector checks: sample half a period after drive (R8)
   task automatic run_wide(input logic [15:0] va, input logic [15:0] vb, input logic vc);
      logic [16:0] tot;
      @(posedge clk); #0.5;
      a = va; b = vb; ci = vc;
      @(negedge clk);
      tot = {1'b0, va} + {1'b0, vb} + {16'b0, vc};
      chk("R1/R8 wide sum", {16'b0, s}, {16'b0, tot[15:0]});
      chk("R2 wide cout", {31'b0, co}, {31'b0, tot[16]});
      for (int k = 0; k < 4; k++) begin
         logic [4:0] sl;
         sl = {1'b0, va[k*4 +: 4]} + {1'b0, vb[k*4 +: 4]};
         chk("R4 wide group gen", {31'b0, bg[k]}, {31'b0, sl[4]});
         chk("R3 wide group prop", {31'b0, bp[k]},
             {31'b0, ((va[k*4 +: 4] ^ vb[k*4 +: 4]) == 4'hF)});
      end
   endtask

   // entries {a, b, cin}
   localparam logic [32:0] VECS [12] = '{
      {16'h0000, 16'h0000, 1'b0},
      {16'hFFFF, 16'h0000, 1'b1},
      {16'hFFFF, 16'hFFFF, 1'b1},
      {16'h0FFF, 16'h0001, 1'b0},
      {16'h00F0, 16'h0F0F, 1'b1},
      {16'h1234, 16'h5678, 1'b0},
      {16'h8000, 16'h8000, 1'b0},
      {16'hAAAA, 16'h5555, 1'b0},
      {16'hAAAA, 16'h5555, 1'b1},
      {16'h7FFF, 16'h0001, 1'b0},
      {16'hF00F, 16'h0FF1, 1'b0},
      {16'hC3A5, 16'h3C5B, 1'b1}
   };

   initial begin
      #200000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      a = '0; b = '0; ci = 1'b0;
      sa = '0; sb = '0; sci = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // idle state with zero inputs
      chk("R1 idle sum", {16'b0, s}, 32'h0);
      chk("R2 idle cout", {31'b0, co}, 32'h0);
      chk("R4 idle gen", {28'b0, bg}, 32'h0);
      chk("R3 idle prop", {28'b0, bp}, 32'h0);

      // table walk
      for (int i = 0; i < 12; i++) begin
         run_wide(VECS[i][32:17], VECS[i][16:1], VECS[i][0]);
      end

      // R7: carry crosses every slice boundary
      run_wide(16'hFFFF, 16'h0000, 1'b1);
      chk("R7 ripple through slices sum", {16'b0, s}, 32'h0);
      chk("R7 ripple through slices cout", {31'b0, co}, 32'h1);

      // exhaustive single slice
      for (int v = 0; v < 512; v++) begin
         logic [4:0] tot;
         logic [4:0] nc;
         logic       gexp, pexp;
         @(posedge clk); #0.5;
         {sa, sb, sci} = v[8:0];
         @(negedge clk);
         tot  = {1'b0, v[8:5]} + {1'b0, v[4:1]} + {4'b0, v[0]};
         nc   = {1'b0, v[8:5]} + {1'b0, v[4:1]};
         gexp = nc[4];
         pexp = ((v[8:5] ^ v[4:1]) == 4'hF);
         chk("R1 slice sum", {28'b0, ss}, {28'b0, tot[3:0]});
         chk("R2 slice cout", {31'b0, sco}, {31'b0, tot[4]});
         chk("R4 slice gen", {31'b0, sg[0]}, {31'b0, gexp});
         chk("R3 slice prop", {31'b0, sp[0]}, {31'b0, pexp});
         chk("R5 slice cout from group", {31'b0, sco}, {31'b0, gexp | (pexp & v[0])});
         if (pexp) begin
            chk("R6 bypass cout", {31'b0, sco}, {31'b0, v[0]});
            chk("R6 bypass sum", {28'b0, ss}, {28'b0, {4{~v[0]}}});
         end
      end

      // random wide vectors
      for (int r = 0; r < 400; r++) begin
         logic [31:0] rv;
         rv = $urandom;
         run_wide(rv[31:16], rv[15:0], rv[7] ^ rv[20]);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule